// File: doc/BRIEF.md
# CPU Interrupt Front End

This block decides, once per instruction, whether an 8-bit CPU core leaves its program flow to service an interrupt. It holds the two interrupt enable flip-flops, the interrupt page register and the interrupt mode. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request. It samples them only when the sequencer signals an instruction boundary, picks at most one of them and delivers the 16-bit service address that the sequencer jumps to.

Decode strobes from the instruction decoder drive the control state: enable, disable, return-from-NMI, copy-enable-to-flag, load-page-register and select-mode. The non-maskable path keeps the maskable enable in a second flip-flop so that the return from the NMI handler can restore it. In the vectored mode the service address is built from the page register and a byte that the peripheral supplies during acknowledge. A combinational wake output tells a halted core that a request is waiting.

Top module: `cpu_irq_front`

## Requirements
- R1: After reset, both enable flip-flops are 0, the page register is 0x00 and the mode is 0. `irq_en` and `wake` are 0, and a following copy-enable strobe gives `pv_flag` = 0.
- R2: `op_ei` sets both enable flip-flops and `op_di` clears both, taking effect at the clock edge. Both are observed through `irq_en` and, after `op_ld_ai`, through `pv_flag`.
- R3: A maskable request (`int_n` low) is taken only at an edge where `instr_end` = 1, `irq_en` = 1, no NMI is pending and no acknowledge is in progress. `take_irq` is a one-cycle pulse in the following cycle.
- R4: A pending NMI wins over a maskable request at the same boundary and is taken whatever the enable state. In the following cycle `take_nmi` = 1, `svc_valid` = 1 and `svc_addr` = 0x0066.
- R5: A falling edge on `nmi_n` is held pending until it is taken, even if the pin goes high again. A pin that stays low after being taken raises no second request.
- R6: Taking an NMI copies the primary enable into the saved enable and then clears the primary enable.
- R7: Taking a maskable interrupt clears both enable flip-flops.
- R8: `op_retn` copies the saved enable back into the primary enable.
- R9: `op_ld_ai` loads `pv_flag` with the saved enable at the clock edge. `pv_flag` holds that value until the next such strobe.
- R10: `op_im` with `im_sel` = 1 selects mode 1. In that mode a taken maskable interrupt gives `svc_valid` = 1 and `svc_addr` = 0x0038 in the same cycle as `take_irq`. Values 0 and 2 select modes 0 and 2, and `im_sel` = 3 leaves the mode unchanged.
- R11: In mode 2 a taken maskable interrupt waits for `vec_valid`. In the cycle after it, `svc_valid` = 1 and `svc_addr` = {page, vec_data[7:1], 0}. Bit 0 is forced to 0, and the page register is loaded from `ld_data` by `op_ld_i`.
- R12: In mode 0 a taken maskable interrupt also waits for `vec_valid`. The address is then the restart address 8 × `vec_data[5:3]`, that is 0x0000 to 0x0038.
- R13: `wake` is 1 whenever an NMI is pending, or whenever `int_n` is low while `irq_en` = 1, with no clock delay.
- R14: While the block is waiting for a vector, instruction boundaries are ignored. An NMI that arrives then stays pending and is taken at the first boundary after the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_end | input | 1 | Instruction boundary strobe |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_di | input | 1 | Disable-interrupts strobe |
| op_retn | input | 1 | Return-from-NMI strobe |
| op_ld_ai | input | 1 | Copy saved enable to flag strobe |
| op_ld_i | input | 1 | Load page register strobe |
| op_im | input | 1 | Select interrupt mode strobe |
| im_sel | input | 2 | Mode value for `op_im` |
| ld_data | input | 8 | Data for page register |
| int_n | input | 1 | Maskable request, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| vec_valid | input | 1 | Peripheral vector byte valid |
| vec_data | input | 8 | Peripheral vector byte |
| take_irq | output | 1 | Maskable interrupt taken (pulse) |
| take_nmi | output | 1 | NMI taken (pulse) |
| svc_valid | output | 1 | Service address valid (pulse) |
| svc_addr | output | 16 | Service address |
| irq_en | output | 1 | Primary enable flip-flop |
| pv_flag | output | 1 | Saved enable as copied for the P/V flag |
| wake | output | 1 | Request waiting (halt exit) |

## Verification
The bench targets the NMI save and restore path. A design that cleared both flip-flops on NMI entry would return `irq_en` = 0 after the return strobe, and one that did not save the enable would report the wrong `pv_flag`. It targets NMI edge latching with a short pulse and with a pin held low: a level-sensitive design either misses the pulse or takes the NMI twice. It drives an NMI and a maskable request to the same boundary, where a wrong priority shows up as `take_irq`. It feeds vectors with bit 0 set and an NMI arriving during the vector wait, exposing an odd service address or an acknowledge cut short by the NMI.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  typedef enum logic [1:0] {
    MODE_RST = 2'd0,
    MODE_FIX = 2'd1,
    MODE_VEC = 2'd2
  } irq_mode_e;

  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_WVEC = 1'b1
  } ack_state_e;
endpackage

// File: rtl/cpu_irq_enables.sv
module cpu_irq_enables (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  input  logic restore,
  input  logic copy_flag,
  input  logic acc_nmi,
  input  logic acc_int,
  output logic iff1,
  output logic iff2,
  output logic flag
);
  logic iff1_nx, iff2_nx, flag_nx;

  always_comb begin
    iff1_nx = iff1;
    iff2_nx = iff2;
    if (acc_nmi) begin
      iff2_nx = iff1;
      iff1_nx = 1'b0;
    end else if (acc_int) begin
      iff1_nx = 1'b0;
      iff2_nx = 1'b0;
    end else if (clr_en) begin
      iff1_nx = 1'b0;
      iff2_nx = 1'b0;
    end else if (set_en) begin
      iff1_nx = 1'b1;
      iff2_nx = 1'b1;
    end else if (restore) begin
      iff1_nx = iff2;
    end
    flag_nx = copy_flag ? iff2 : flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      flag <= 1'b0;
    end else begin
      iff1 <= iff1_nx;
      iff2 <= iff2_nx;
      flag <= flag_nx;
    end
  end
endmodule

// File: rtl/cpu_irq_nmi_edge.sv
module cpu_irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic consume,
  output logic pending
);
  logic nmi_q, fall, pend_nx;

  always_comb begin
    fall    = nmi_q & ~nmi_n;
    pend_nx = (pending & ~consume) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q   <= 1'b1;
      pending <= 1'b0;
    end else begin
      nmi_q   <= nmi_n;
      pending <= pend_nx;
    end
  end
endmodule

// File: rtl/cpu_irq_vector.sv
module cpu_irq_vector
  import cpu_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 16'h0066,
  parameter logic [ADDR_W-1:0] FIX_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_nmi,
  input  logic              acc_int,
  input  logic              vec_valid,
  input  logic [DATA_W-1:0] vec_data,
  input  logic              op_ld_i,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              op_im,
  input  logic [1:0]        im_sel,
  output logic              idle,
  output logic              take_nmi,
  output logic              take_irq,
  output logic              svc_valid,
  output logic [ADDR_W-1:0] svc_addr
);
  localparam int RST_PAD = ADDR_W - 6;

  irq_mode_e         mode, mode_nx;
  ack_state_e        st, st_nx;
  logic [DATA_W-1:0] page, page_nx;
  logic              tn_nx, ti_nx, sv_nx;
  logic [ADDR_W-1:0] sa_nx, rst_addr, vec_addr;

  always_comb begin
    rst_addr = {{RST_PAD{1'b0}}, vec_data[5:3], 3'b000};
    vec_addr = {page, vec_data[DATA_W-1:1], 1'b0};
    mode_nx  = mode;
    if (op_im && im_sel != 2'd3) mode_nx = irq_mode_e'(im_sel);
    page_nx  = op_ld_i ? ld_data : page;
    st_nx    = st;
    tn_nx    = 1'b0;
    ti_nx    = 1'b0;
    sv_nx    = 1'b0;
    sa_nx    = svc_addr;
    if (st == ACK_IDLE) begin
      if (acc_nmi) begin
        tn_nx = 1'b1;
        sv_nx = 1'b1;
        sa_nx = NMI_ADDR;
      end else if (acc_int) begin
        ti_nx = 1'b1;
        if (mode == MODE_FIX) begin
          sv_nx = 1'b1;
          sa_nx = FIX_ADDR;
        end else begin
          st_nx = ACK_WVEC;
        end
      end
    end else if (vec_valid) begin
      st_nx = ACK_IDLE;
      sv_nx = 1'b1;
      sa_nx = (mode == MODE_VEC) ? vec_addr : rst_addr;
    end
    idle = (st == ACK_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_RST;
      page      <= '0;
      st        <= ACK_IDLE;
      take_nmi  <= 1'b0;
      take_irq  <= 1'b0;
      svc_valid <= 1'b0;
      svc_addr  <= '0;
    end else begin
      mode      <= mode_nx;
      page      <= page_nx;
      st        <= st_nx;
      take_nmi  <= tn_nx;
      take_irq  <= ti_nx;
      svc_valid <= sv_nx;
      svc_addr  <= sa_nx;
    end
  end
endmodule

// File: rtl/cpu_irq_front.sv
module cpu_irq_front #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_end,
  input  logic              op_ei,
  input  logic              op_di,
  input  logic              op_retn,
  input  logic              op_ld_ai,
  input  logic              op_ld_i,
  input  logic              op_im,
  input  logic [1:0]        im_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              int_n,
  input  logic              nmi_n,
  input  logic              vec_valid,
  input  logic [DATA_W-1:0] vec_data,
  output logic              take_irq,
  output logic              take_nmi,
  output logic              svc_valid,
  output logic [ADDR_W-1:0] svc_addr,
  output logic              irq_en,
  output logic              pv_flag,
  output logic              wake
);
  logic iff1, iff2, nmi_pend, idle, acc_nmi, acc_int;

  always_comb begin
    acc_nmi = instr_end & idle & nmi_pend;
    acc_int = instr_end & idle & ~nmi_pend & ~int_n & iff1;
    irq_en  = iff1;
    wake    = nmi_pend | (~int_n & iff1);
  end

  cpu_irq_enables u_en (
    .clk(clk), .rst_n(rst_n), .set_en(op_ei), .clr_en(op_di),
    .restore(op_retn), .copy_flag(op_ld_ai), .acc_nmi(acc_nmi),
    .acc_int(acc_int), .iff1(iff1), .iff2(iff2), .flag(pv_flag)
  );

  cpu_irq_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .consume(acc_nmi),
    .pending(nmi_pend)
  );

  cpu_irq_vector #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .acc_nmi(acc_nmi), .acc_int(acc_int),
    .vec_valid(vec_valid), .vec_data(vec_data), .op_ld_i(op_ld_i),
    .ld_data(ld_data), .op_im(op_im), .im_sel(im_sel), .idle(idle),
    .take_nmi(take_nmi), .take_irq(take_irq), .svc_valid(svc_valid),
    .svc_addr(svc_addr)
  );
endmodule

// File: rtl/cpu_irq_front_chk.sv
module cpu_irq_front_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_end,
  input logic              int_n,
  input logic              op_ei,
  input logic              take_irq,
  input logic              take_nmi,
  input logic              svc_valid,
  input logic [ADDR_W-1:0] svc_addr,
  input logic              irq_en,
  input logic              acc_nmi,
  input logic              acc_int
);
  // R4
  nmi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> (svc_valid && svc_addr == 16'h0066));
  // R4
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_irq}));
  // R3
  int_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(instr_end) && !$past(int_n) && $past(irq_en)));
  // R7
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq || take_nmi) |-> !irq_en);
  // R11
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !take_nmi && !take_irq) |-> !svc_addr[0]);
  // R2
  ei_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ei && !acc_nmi && !acc_int) |=> irq_en);
endmodule

bind cpu_irq_front cpu_irq_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .int_n(int_n),
  .op_ei(op_ei), .take_irq(take_irq), .take_nmi(take_nmi),
  .svc_valid(svc_valid), .svc_addr(svc_addr), .irq_en(irq_en),
  .acc_nmi(acc_nmi), .acc_int(acc_int)
);

// File: tb/cpu_irq_front_bench.sv
`timescale 1ns/100ps
module cpu_irq_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_end = 0, op_ei = 0, op_di = 0, op_retn = 0, op_ld_ai = 0;
  logic op_ld_i = 0, op_im = 0, int_n = 1, nmi_n = 1, vec_valid = 0;
  logic [1:0] im_sel = 0;
  logic [7:0] ld_data = 0, vec_data = 0;
  logic take_irq, take_nmi, svc_valid, irq_en, pv_flag, wake;
  logic [15:0] svc_addr;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu_irq_front u_cpu_irq_front (.*);

  // row: [7:6] op (0 none, 1 ei, 2 di), [5] int_n, [4] instr_end,
  //      [3] expected irq_en, [2] expected take_irq, [1] expected svc_valid
  localparam logic [7:0] TBL [9] = '{
    8'b00_0_1_0_0_0_0, 8'b01_1_0_1_0_0_0, 8'b00_0_0_1_0_0_0,
    8'b00_0_1_0_1_1_0, 8'b00_0_1_0_0_0_0, 8'b01_1_0_1_0_0_0,
    8'b10_1_0_0_0_0_0, 8'b01_1_0_1_0_0_0, 8'b00_1_1_1_0_0_0
  };

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    instr_end = 0; op_ei = 0; op_di = 0; op_retn = 0; op_ld_ai = 0;
    op_ld_i = 0; op_im = 0; vec_valid = 0;
  endtask

  task automatic set_mode(logic [1:0] m);
    op_im = 1; im_sel = m; step();
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_en", irq_en, 0);
    chk("R1 wake", wake, 0);
    chk("R1 svc_valid", svc_valid, 0);
    op_ld_ai = 1; step();
    chk("R1 pv_flag", pv_flag, 0);
    // R12 mode 0 after reset: restart address from vector
    op_ei = 1; step();
    chk("R2 ei", irq_en, 1);
    op_ld_ai = 1; step();
    chk("R2 saved via pv", pv_flag, 1);
    int_n = 0; instr_end = 1; step();
    chk("R12 take", take_irq, 1);
    chk("R12 wait vec", svc_valid, 0);
    int_n = 1;
    vec_data = 8'hFF; vec_valid = 1; step();
    chk("R12 addr valid", svc_valid, 1);
    chk("R12 addr", svc_addr, 16'h0038);
    // R1 page register zero, R11 bit0 forced
    set_mode(2'd2);
    op_ei = 1; step();
    int_n = 0; instr_end = 1; step();
    int_n = 1;
    vec_data = 8'h5B; vec_valid = 1; step();
    chk("R11 page0 addr", svc_addr, 16'h005A);
    // R14 NMI during vector wait
    op_ld_i = 1; ld_data = 8'hA3; step();
    op_ei = 1; step();
    int_n = 0; instr_end = 1; step();
    int_n = 1;
    nmi_n = 0; step();
    nmi_n = 1; instr_end = 1; step();
    chk("R14 no nmi in wait", take_nmi, 0);
    chk("R14 still pending", wake, 1);
    vec_data = 8'h11; vec_valid = 1; step();
    chk("R11 addr", svc_addr, 16'hA310);
    instr_end = 1; step();
    chk("R14 nmi after vec", take_nmi, 1);
    chk("R4 nmi addr", svc_addr, 16'h0066);
    // table walk in mode 1 (R3 R7 R2 R10)
    set_mode(2'd3);
    set_mode(2'd1);
    op_di = 1; step();
    foreach (TBL[i]) begin
      op_ei = (TBL[i][7:6] == 2'd1);
      op_di = (TBL[i][7:6] == 2'd2);
      int_n = TBL[i][5];
      instr_end = TBL[i][4];
      step();
      chk($sformatf("R3 row%0d en", i), irq_en, TBL[i][3]);
      chk($sformatf("R3 row%0d take", i), take_irq, TBL[i][2]);
      chk($sformatf("R10 row%0d sv", i), svc_valid, TBL[i][1]);
      if (TBL[i][1]) chk("R10 fixed addr", svc_addr, 16'h0038);
    end
    int_n = 1;
    // R13 wake
    op_ei = 1; step();
    int_n = 0; #1;
    chk("R13 wake int", wake, 1);
    op_di = 1; step();
    chk("R13 no wake disabled", wake, 0);
    int_n = 1;
    // R4 R6 R8: NMI with enable set, simultaneous INT
    op_ei = 1; step();
    nmi_n = 0; step();
    chk("R13 wake nmi", wake, 1);
    int_n = 0; instr_end = 1; step();
    chk("R4 nmi wins", take_nmi, 1);
    chk("R4 no irq", take_irq, 0);
    chk("R6 iff1 cleared", irq_en, 0);
    int_n = 1;
    op_ld_ai = 1; step();
    chk("R9 R6 saved kept", pv_flag, 1);
    // R5 held low: no retrigger
    instr_end = 1; step();
    chk("R5 no retrigger", take_nmi, 0);
    op_retn = 1; step();
    chk("R8 restore", irq_en, 1);
    nmi_n = 1;
    // R5 short pulse with enables clear
    op_di = 1; step();
    nmi_n = 0; step();
    nmi_n = 1; step(); step();
    instr_end = 1; step();
    chk("R5 latched pulse", take_nmi, 1);
    op_ld_ai = 1; step();
    chk("R6 saved copy zero", pv_flag, 0);
    op_retn = 1; step();
    chk("R8 restore zero", irq_en, 0);
    op_ei = 1; step();
    op_di = 1; step();
    op_ld_ai = 1; step();
    chk("R2 di clears saved", pv_flag, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule